// File: doc/BRIEF.md
# Load/Store Bus Cycle Sequencer

This block sequences the memory bus for one load or one store at a time. It belongs to a small three-stage pipelined core. When idle, it fetches instructions back to back from an internal program counter. A start pulse hands it an operation together with its operands: the effective address, the destination register, a flag that marks that destination as the program counter, and the store data. The block then runs a fixed sequence of bus cycles. In each cycle it drives the address, the write strobe and write data, and the register write-back controls. When the operation is complete it gives a single-cycle completion pulse.

The two cycle-type outputs describe the bus cycle that follows, one cycle ahead of it. Three encodings are used, given as (`memReqN`, `seqNext`):

- (0,0) means the next cycle is non-sequential.
- (1,0) means the next cycle is internal, with no memory access.
- (0,1) means the next cycle is sequential.

A load spends one internal cycle writing its data back. A store has no internal cycle. A load whose destination is the program counter also refills the fetch stream from the loaded target.

Top module: `ls_bus_sequencer`

## Requirements
- R1: While reset is active and in the first cycle after it, `addrBus` is 0, (`memReqN`,`seqNext`) is (0,1), and `writeEn`, `regWrEn` and `opDone` are 0.
- R2: In every idle cycle, `addrBus` equals the program counter and the block announces a sequential cycle (0,1). The program counter then advances by 4.
- R3: A start with `opIsStore`=0 and `dstIsPc`=0 runs three further cycles. The first cycle drives the program counter, advances it by 4 and announces (0,0). The second cycle drives the latched effective address and announces (1,0). The third cycle drives the program counter, announces (0,1) and returns to idle.
- R4: `readData` is sampled at the clock edge that ends the second load cycle. In the third cycle, `regWrEn`=1, `regWrIdx` is the latched destination and `regWrData` is the sampled word.
- R5: A load with `dstIsPc`=1 runs the first two cycles of R3. Its third cycle drives the sampled word on `addrBus`, announces (0,0), loads that word into the program counter and leaves `regWrEn` at 0. Two fetch cycles follow, at the target and at the target plus 4. Both announce (0,1).
- R6: A start with `opIsStore`=1 runs two cycles. The first drives the program counter, advances it by 4 and announces (0,0). The second drives the effective address with `writeEn`=1 and `writeData` equal to the latched store data, and announces (0,0).
- R7: `writeEn` is 1 only in the store data cycle. `writeData` is 0 in every other cycle.
- R8: `opDone` is 1 for exactly one cycle per operation: the third cycle of a load (R3), the fifth cycle of a program-counter load (R5), and the second cycle of a store (R6).
- R9: A start pulse is ignored unless the block is idle. An operation is always followed by an idle fetch cycle.
- R10: All operands are captured at the accepted start. Later changes on `opIsStore`, `effAddr`, `dstReg`, `dstIsPc` and `storeData` have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, accepted only when idle |
| opIsStore | input | 1 | 1 = store, 0 = load |
| effAddr | input | 32 | Effective data address |
| dstReg | input | 4 | Load destination register index |
| dstIsPc | input | 1 | Load destination is the program counter |
| storeData | input | 32 | Data to be stored |
| readData | input | 32 | Data returned by memory |
| addrBus | output | 32 | Bus address of the current cycle |
| memReqN | output | 1 | Active-low memory request for the next cycle |
| seqNext | output | 1 | Next cycle is sequential |
| writeEn | output | 1 | Write strobe |
| writeData | output | 32 | Data driven for a write |
| regWrEn | output | 1 | Register write-back enable |
| regWrIdx | output | 4 | Register write-back index |
| regWrData | output | 32 | Register write-back data |
| opDone | output | 1 | Single-cycle completion pulse |

## Verification
The hardest case to reach is the program-counter load. The fetch address after it comes only from the word the memory returned, at the one clock edge that ends the read cycle. To make that word predictable, the bench models memory as an arithmetic function of `addrBus`, so any sampling in the wrong cycle produces an address the bench does not expect. The bench sweeps every destination index for each of the three operation kinds, with varying idle gaps between operations. During every busy cycle it holds `start` high and scrambles the operand inputs, so that both the busy-ignore rule and operand capture are exercised at once.

// File: rtl/ls_seq_pkg.sv
package ls_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READ,
    ST_WBACK,
    ST_REFILL1,
    ST_REFILL2,
    ST_WRITE
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_PC,
    SEL_EFF,
    SEL_CAPT
  } addrSel_t;

  typedef struct packed {
    logic     latchOps;
    logic     pcInc;
    logic     pcLoad;
    logic     captureRd;
    logic     driveWr;
    addrSel_t addrSel;
  } ctlStrobes_t;

endpackage

// File: rtl/ls_seq_ctrl.sv
module ls_seq_ctrl
  import ls_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        opIsStore,
  input  logic        dstIsPc,
  output ctlStrobes_t strobes,
  output logic        memReqN,
  output logic        seqNext,
  output logic        regWrEn,
  output logic        opDone
);

  seqState_t state, stateNxt;
  logic      isStoreQ, isPcQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      isStoreQ <= 1'b0;
      isPcQ    <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobes.latchOps) begin
        isStoreQ <= opIsStore;
        isPcQ    <= dstIsPc;
      end
    end
  end

  always_comb begin
    stateNxt = state;
    strobes  = '{latchOps: 1'b0, pcInc: 1'b0, pcLoad: 1'b0,
                 captureRd: 1'b0, driveWr: 1'b0, addrSel: SEL_PC};
    memReqN  = 1'b0;
    seqNext  = 1'b1;
    regWrEn  = 1'b0;
    opDone   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobes.pcInc    = 1'b1;
        strobes.latchOps = start;
        if (start) stateNxt = ST_ADDR;
      end
      ST_ADDR: begin
        strobes.pcInc = 1'b1;
        seqNext       = 1'b0;
        stateNxt      = isStoreQ ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        strobes.addrSel   = SEL_EFF;
        strobes.captureRd = 1'b1;
        memReqN           = 1'b1;
        seqNext           = 1'b0;
        stateNxt          = ST_WBACK;
      end
      ST_WBACK: begin
        if (isPcQ) begin
          strobes.addrSel = SEL_CAPT;
          strobes.pcLoad  = 1'b1;
          seqNext         = 1'b0;
          stateNxt        = ST_REFILL1;
        end else begin
          regWrEn  = 1'b1;
          opDone   = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_REFILL1: begin
        strobes.pcInc = 1'b1;
        stateNxt      = ST_REFILL2;
      end
      ST_REFILL2: begin
        strobes.pcInc = 1'b1;
        opDone        = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_WRITE: begin
        strobes.addrSel = SEL_EFF;
        strobes.driveWr = 1'b1;
        seqNext         = 1'b0;
        opDone          = 1'b1;
        stateNxt        = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // Encoding (memReqN=1, seqNext=1) is never produced
  p_no_reserved_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(memReqN && seqNext));

  // Completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> !opDone);

  // An announced internal cycle never carries a write
  p_internal_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    memReqN |=> !strobes.driveWr);

  // Write-back only follows an announced internal cycle
  p_wback_after_internal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> $past(memReqN));

  // Store data cycle completes the store
  p_write_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.driveWr |-> opDone);

endmodule

// File: rtl/ls_seq_datapath.sv
module ls_seq_datapath
  import ls_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [REG_W-1:0]  dstReg,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readData,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] writeData,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [DATA_W-1:0] regWrData
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] pcQ, effQ;
  logic [DATA_W-1:0] storeQ, captQ;
  logic [REG_W-1:0]  dstQ;
  logic [ADDR_W-1:0] captAddr;

  // Loaded word as an address: truncate or zero-extend
  generate
    if (DATA_W >= ADDR_W) begin : g_capt_trunc
      assign captAddr = captQ[ADDR_W-1:0];
    end else begin : g_capt_ext
      assign captAddr = {{(ADDR_W-DATA_W){1'b0}}, captQ};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcQ    <= '0;
      effQ   <= '0;
      storeQ <= '0;
      captQ  <= '0;
      dstQ   <= '0;
    end else begin
      if (strobes.pcLoad)      pcQ <= captAddr;
      else if (strobes.pcInc)  pcQ <= pcQ + PC_STEP;
      if (strobes.latchOps) begin
        effQ   <= effAddr;
        storeQ <= storeData;
        dstQ   <= dstReg;
      end
      if (strobes.captureRd) captQ <= readData;
    end
  end

  always_comb begin
    unique case (strobes.addrSel)
      SEL_EFF:  addrBus = effQ;
      SEL_CAPT: addrBus = captAddr;
      default:  addrBus = pcQ;
    endcase
  end

  assign writeData = strobes.driveWr ? storeQ : '0;
  assign regWrIdx  = dstQ;
  assign regWrData = captQ;

  // Each fetch steps the program counter by one instruction
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.pcInc && !strobes.pcLoad) |=> pcQ == $past(pcQ) + PC_STEP);

  // A program-counter load takes the captured word
  p_pc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pcLoad |=> pcQ == $past(captAddr));

  // Captured data only changes on a capture strobe
  p_capt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.captureRd |=> $stable(captQ));

endmodule

// File: rtl/ls_bus_sequencer.sv
module ls_bus_sequencer
  import ls_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              opIsStore,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [REG_W-1:0]  dstReg,
  input  logic              dstIsPc,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readData,
  output logic [ADDR_W-1:0] addrBus,
  output logic              memReqN,
  output logic              seqNext,
  output logic              writeEn,
  output logic [DATA_W-1:0] writeData,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              opDone
);

  ctlStrobes_t strobes;

  ls_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opIsStore (opIsStore),
    .dstIsPc   (dstIsPc),
    .strobes   (strobes),
    .memReqN   (memReqN),
    .seqNext   (seqNext),
    .regWrEn   (regWrEn),
    .opDone    (opDone)
  );

  ls_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .effAddr   (effAddr),
    .dstReg    (dstReg),
    .storeData (storeData),
    .readData  (readData),
    .addrBus   (addrBus),
    .writeData (writeData),
    .regWrIdx  (regWrIdx),
    .regWrData (regWrData)
  );

  assign writeEn = strobes.driveWr;

endmodule

// File: tb/tb_ls_bus_sequencer.sv
module tb_ls_bus_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        opIsStore = 1'b0;
  logic [31:0] effAddr = '0;
  logic [3:0]  dstReg = '0;
  logic        dstIsPc = 1'b0;
  logic [31:0] storeData = '0;
  logic [31:0] readData;
  logic [31:0] addrBus;
  logic        memReqN, seqNext, writeEn, regWrEn, opDone;
  logic [31:0] writeData, regWrData;
  logic [3:0]  regWrIdx;

  int checks = 0;
  int fails = 0;
  logic [31:0] pcModel = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a * 32'd5) ^ 32'h3C00_0A00;
  endfunction

  assign readData = memFn(addrBus);

  ls_bus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opIsStore(opIsStore),
    .effAddr(effAddr), .dstReg(dstReg), .dstIsPc(dstIsPc),
    .storeData(storeData), .readData(readData), .addrBus(addrBus),
    .memReqN(memReqN), .seqNext(seqNext), .writeEn(writeEn),
    .writeData(writeData), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .opDone(opDone)
  );

  task automatic chk(input string req, input logic [31:0] eAddr,
                     input logic eReqN, input logic eSeq, input logic eWe,
                     input logic [31:0] eWd, input logic eRwe,
                     input logic [3:0] eIdx, input logic [31:0] eRd,
                     input logic eDone);
    bit bad;
    checks++;
    bad = (addrBus !== eAddr) || (memReqN !== eReqN) || (seqNext !== eSeq) ||
          (writeEn !== eWe) || (writeData !== eWd) || (regWrEn !== eRwe) ||
          (opDone !== eDone) ||
          (eRwe && ((regWrIdx !== eIdx) || (regWrData !== eRd)));
    if (bad) begin
      fails++;
      $display("FAIL %s: got addr=%h rq=%b sq=%b we=%b wd=%h rwe=%b idx=%h rd=%h dn=%b exp addr=%h rq=%b sq=%b we=%b wd=%h rwe=%b idx=%h rd=%h dn=%b",
        req, addrBus, memReqN, seqNext, writeEn, writeData, regWrEn, regWrIdx,
        regWrData, opDone, eAddr, eReqN, eSeq, eWe, eWd, eRwe, eIdx, eRd, eDone);
    end
  endtask

  task automatic idleChk(input string req);
    chk(req, pcModel, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0);
  endtask

  // kind: 0 = load, 1 = load to program counter, 2 = store
  task automatic runOp(input int kind, input int dst, input int gap);
    logic [31:0] ea, sd, rd;
    ea = 32'h0000_1000 + 32'(kind) * 32'h100 + 32'(dst) * 32'h8;
    sd = 32'hC0DE_0000 + 32'(dst) * 32'h11 + 32'(kind);
    repeat (gap) begin
      idleChk("R2");
      pcModel += 4;
      @(negedge clk);
    end
    idleChk("R2");
    start = 1'b1; opIsStore = (kind == 2); effAddr = ea;
    dstReg = 4'(dst); dstIsPc = (kind == 1); storeData = sd;
    pcModel += 4;
    @(negedge clk);
    // first cycle; scramble operands and keep start high (R9, R10)
    effAddr = ~ea; storeData = ~sd; dstReg = ~4'(dst);
    dstIsPc = (kind != 1); opIsStore = (kind != 2);
    chk(kind == 2 ? "R6" : "R3", pcModel, 1'b0, 1'b0, 1'b0, 32'h0,
        1'b0, 4'h0, 32'h0, 1'b0);
    pcModel += 4;
    @(negedge clk);
    if (kind == 2) begin
      chk("R6 R7 R8 R10", ea, 1'b0, 1'b0, 1'b1, sd, 1'b0, 4'h0, 32'h0, 1'b1);
      @(negedge clk);
    end else begin
      chk("R3 R10", ea, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0);
      rd = memFn(ea);
      @(negedge clk);
      if (kind == 0) begin
        chk("R4 R8", pcModel, 1'b0, 1'b1, 1'b0, 32'h0, 1'b1, 4'(dst), rd, 1'b1);
        @(negedge clk);
      end else begin
        chk("R5", rd, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0);
        pcModel = rd;
        @(negedge clk);
        chk("R5", pcModel, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0);
        pcModel += 4;
        @(negedge clk);
        chk("R5 R8", pcModel, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b1);
        pcModel += 4;
        @(negedge clk);
      end
    end
    start = 1'b0;
    // start held through the busy cycles must not have been taken (R9)
    idleChk("R9");
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    start = 1'b1;  // R1: start during reset has no effect
    repeat (3) @(negedge clk);
    chk("R1", 32'h0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0);
    start = 1'b0;
    rst_n = 1'b1;
    chk("R1", 32'h0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0);
    for (int kind = 0; kind < 3; kind++) begin
      for (int dst = 0; dst < 16; dst++) begin
        runOp(kind, dst, dst % 3);
      end
    end
    // mixed ordering, back to back
    for (int i = 0; i < 9; i++) runOp(i % 3, 15 - i, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule